// File: doc/BRIEF.md
# Polling Bus Master for a Flow-Control-Free SPI Slave Peripheral

This block drives a register-mapped SPI slave peripheral over a Wishbone classic bus. It keeps reading the peripheral's status register, and the flags it finds decide its next access. It writes the next outgoing byte when the transmit holding register is empty. It reads each incoming byte as soon as one is waiting. The peripheral cannot stall its serial side, so every byte must be serviced before the next byte boundary.

Every bus access is built as the peripheral requires. The bus controls are low for at least one cycle, then they are raised, then they are held until the acknowledge arrives. Two accesses are never joined back to back. A status read therefore never runs straight into a transmit write.

An operation starts when the transfer-in-progress flag rises, which happens when the master asserts chip select. It ends when that flag falls. The first transmit byte is written only after transfer-in-progress and transmit-ready have both been seen, because the first serial clock may come many cycles after chip select. The application side has three handshakes: a byte-out taken pulse, a byte-in valid pulse, and an end-of-operation pulse.

Top module: `spi_poll_svc`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the block holds `wb_cyc_o`, `wb_stb_o`, `rx_valid_o`, `tx_taken_o`, `op_done_o` and `tip_o` low.
- R2: `wb_stb_o` always equals `wb_cyc_o`. Before every rise of `wb_cyc_o`, the controls have been low for at least `GAP_CYCLES` cycles.
- R3: Once raised, `wb_cyc_o` and the address, write-enable and write data stay unchanged until `wb_ack_i` is sampled high. In the cycle after that, `wb_cyc_o` is low.
- R4: The status register (default address 0x06) is read with `wb_we_o` low. It is read again, with the idle gap in between, until a flag calls for a different access. Outside an operation, status reads are the only accesses.
- R5: Status bit 7 is transfer-in-progress (TIP) and bit 4 is transmit-ready (TRDY). The first transmit write of an operation happens only after one status read showed both bits set.
- R6: During an operation, a status read with bit 3 (receive-ready, RRDY) set is followed by a read of the receive register (default 0x0E). The byte read appears on `rx_byte_o` with a one-cycle `rx_valid_o` pulse.
- R7: During an operation, a status read with TRDY set and RRDY clear is followed by a write of `tx_byte_i` to the transmit register (default 0x0D). The write is the only kind of write issued. A one-cycle `tx_taken_o` pulse follows each completed write.
- R8: During an operation, a status read with TIP and RRDY both clear ends the operation. The block gives one `op_done_o` pulse and returns to waiting for TIP and TRDY.
- R9: `tip_o` equals the TIP bit of the most recently completed status read.
- R10: When RRDY and TRDY are both set during an operation, the receive read goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe, equal to cycle |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | ADDR_W | Register address |
| wb_dat_o | output | 8 | Write data |
| wb_dat_i | input | 8 | Read data |
| wb_ack_i | input | 1 | Access acknowledge |
| tx_byte_i | input | 8 | Next byte to send, held until taken |
| tx_taken_o | output | 1 | Pulse: `tx_byte_i` was written to the peripheral |
| rx_byte_o | output | 8 | Last byte received |
| rx_valid_o | output | 1 | Pulse: `rx_byte_o` holds a new byte |
| op_done_o | output | 1 | Pulse: the operation has ended |
| tip_o | output | 1 | TIP from the latest status read, for debug |

## Verification
The hardest case to reach is the byte boundary, where RRDY and TRDY rise together while a status read is already in flight. At that moment the polling loop must spend one stale read, then take the receive byte, then write the next transmit byte, all before the following boundary. The bench models the peripheral's serial timing in bus cycles and sweeps acknowledge latency, chip-select-to-first-clock delay, byte period and end-of-operation tail. The shortest byte period and the slowest acknowledge land the boundary at every phase of the poll loop. Any late service then shows up as a transmit underrun or a receive overrun in the model.

// File: rtl/spi_poll_pkg.sv
// Package: shared encodings for the polling SPI service controller.
// Assumes an 8-bit peripheral data path with fixed status flag positions.
package spi_poll_pkg;
    localparam int BYTE_W   = 8;
    localparam int TIP_BIT  = 7;
    localparam int TRDY_BIT = 4;
    localparam int RRDY_BIT = 3;

    // Kind of bus access the controller issues next.
    typedef enum logic [1:0] {
        OP_STAT = 2'd0,
        OP_RDRX = 2'd1,
        OP_WRTX = 2'd2
    } op_e;
endpackage

// File: rtl/wbm_gap_port.sv
// Module: Wishbone classic master port that runs one access per request.
// It keeps CYC/STB low for at least GAP_CYCLES cycles between accesses.
// Assumes the requester pulses go only while no access is pending or active,
// and that the slave acknowledges within a bounded time.
module wbm_gap_port #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int GAP_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_we,
    input  logic [ADDR_W-1:0] go_adr,
    input  logic [DATA_W-1:0] go_dat,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_adr,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack
);
    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic          pend;
    logic [CW-1:0] gap_cnt;
    logic          gap_ok;

    // Purpose: the idle gap has been met once this low cycle ends.
    always_comb gap_ok = (int'(gap_cnt) >= GAP_CYCLES - 1);

    assign wb_stb = wb_cyc;

    // Purpose: capture a request, start it after the gap, end it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_cyc   <= 1'b0;
            wb_we    <= 1'b0;
            wb_adr   <= '0;
            wb_dat_o <= '0;
            pend     <= 1'b0;
            gap_cnt  <= '0;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                pend     <= 1'b1;
                wb_we    <= go_we;
                wb_adr   <= go_adr;
                wb_dat_o <= go_dat;
            end
            if (wb_cyc) begin
                if (wb_ack) begin
                    wb_cyc  <= 1'b0;
                    done    <= 1'b1;
                    rdata   <= wb_dat_i;
                    gap_cnt <= '0;
                end
            end else begin
                if (int'(gap_cnt) < GAP_CYCLES)
                    gap_cnt <= gap_cnt + 1'b1;
                if ((pend || go) && gap_ok) begin
                    wb_cyc <= 1'b1;
                    pend   <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/spi_poll_fsm.sv
// Module: polling decision machine. After each finished access it picks the
// next one from the status flags. Before an operation it waits for TIP and
// TRDY together. During an operation receive reads take priority over
// transmit writes, and TIP low ends the operation.
// Assumes at most one access outstanding and the status bits from the package.
module spi_poll_fsm
    import spi_poll_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'h06,
    parameter logic [ADDR_W-1:0] TXD_ADDR  = 'h0D,
    parameter logic [ADDR_W-1:0] RXD_ADDR  = 'h0E
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              go,
    output logic              go_we,
    output logic [ADDR_W-1:0] go_adr,
    output logic [BYTE_W-1:0] go_dat,
    input  logic              done,
    input  logic [BYTE_W-1:0] rdata,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              tx_taken_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic              op_done_o,
    output logic              tip_o
);
    typedef enum logic {C_ISSUE, C_WAIT} cst_e;

    cst_e cst;
    op_e  op;
    logic running;
    logic s_tip, s_trdy, s_rrdy;

    // Purpose: decode the flags of the word just read.
    always_comb begin
        s_tip  = rdata[TIP_BIT];
        s_trdy = rdata[TRDY_BIT];
        s_rrdy = rdata[RRDY_BIT];
    end

    // Purpose: present the chosen access to the bus port.
    always_comb begin
        go     = (cst == C_ISSUE);
        go_we  = (op == OP_WRTX);
        go_dat = tx_byte_i;
        case (op)
            OP_RDRX: go_adr = RXD_ADDR;
            OP_WRTX: go_adr = TXD_ADDR;
            default: go_adr = STAT_ADDR;
        endcase
    end

    // Purpose: choose the next access and raise the application pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cst        <= C_ISSUE;
            op         <= OP_STAT;
            running    <= 1'b0;
            tip_o      <= 1'b0;
            tx_taken_o <= 1'b0;
            rx_valid_o <= 1'b0;
            op_done_o  <= 1'b0;
            rx_byte_o  <= '0;
        end else begin
            tx_taken_o <= 1'b0;
            rx_valid_o <= 1'b0;
            op_done_o  <= 1'b0;
            case (cst)
                C_ISSUE: cst <= C_WAIT;
                default: begin
                    if (done) begin
                        cst <= C_ISSUE;
                        case (op)
                            OP_STAT: begin
                                tip_o <= s_tip;
                                if (!running) begin
                                    if (s_tip && s_trdy) begin
                                        op      <= OP_WRTX;
                                        running <= 1'b1;
                                    end
                                end else if (s_rrdy) begin
                                    op <= OP_RDRX;
                                end else if (!s_tip) begin
                                    running   <= 1'b0;
                                    op_done_o <= 1'b1;
                                end else if (s_trdy) begin
                                    op <= OP_WRTX;
                                end
                            end
                            OP_RDRX: begin
                                rx_byte_o  <= rdata;
                                rx_valid_o <= 1'b1;
                                op         <= OP_STAT;
                            end
                            default: begin
                                tx_taken_o <= 1'b1;
                                op         <= OP_STAT;
                            end
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_poll_svc.sv
// Module: top of the polling SPI service controller. It joins the decision
// machine to the gapped Wishbone master port.
// Assumes the SPI clock is at most half the bus clock and that the access
// loop fits inside one serial byte time.
module spi_poll_svc
    import spi_poll_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                GAP_CYCLES = 1,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 'h06,
    parameter logic [ADDR_W-1:0] TXD_ADDR   = 'h0D,
    parameter logic [ADDR_W-1:0] RXD_ADDR   = 'h0E
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [7:0]        wb_dat_o,
    input  logic [7:0]        wb_dat_i,
    input  logic              wb_ack_i,
    input  logic [7:0]        tx_byte_i,
    output logic              tx_taken_o,
    output logic [7:0]        rx_byte_o,
    output logic              rx_valid_o,
    output logic              op_done_o,
    output logic              tip_o
);
    logic              go, go_we, done;
    logic [ADDR_W-1:0] go_adr;
    logic [BYTE_W-1:0] go_dat, rdata;

    spi_poll_fsm #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
        .TXD_ADDR(TXD_ADDR), .RXD_ADDR(RXD_ADDR)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_we(go_we), .go_adr(go_adr), .go_dat(go_dat),
        .done(done), .rdata(rdata),
        .tx_byte_i(tx_byte_i), .tx_taken_o(tx_taken_o),
        .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o),
        .op_done_o(op_done_o), .tip_o(tip_o)
    );

    wbm_gap_port #(
        .ADDR_W(ADDR_W), .DATA_W(BYTE_W), .GAP_CYCLES(GAP_CYCLES)
    ) u_port (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_we(go_we), .go_adr(go_adr), .go_dat(go_dat),
        .done(done), .rdata(rdata),
        .wb_cyc(wb_cyc_o), .wb_stb(wb_stb_o), .wb_we(wb_we_o),
        .wb_adr(wb_adr_o), .wb_dat_o(wb_dat_o),
        .wb_dat_i(wb_dat_i), .wb_ack(wb_ack_i)
    );
endmodule

// File: rtl/spi_poll_svc_chk.sv
// Module: protocol checker for spi_poll_svc, attached by bind.
// Assumes the slave acknowledge is sampled only while CYC is high.
module spi_poll_svc_chk #(
    parameter int                ADDR_W     = 8,
    parameter int                GAP_CYCLES = 1,
    parameter logic [ADDR_W-1:0] TXD_ADDR   = 'h0D,
    parameter logic [ADDR_W-1:0] RXD_ADDR   = 'h0E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wb_cyc_o,
    input logic              wb_stb_o,
    input logic              wb_we_o,
    input logic [ADDR_W-1:0] wb_adr_o,
    input logic [7:0]        wb_dat_o,
    input logic              wb_ack_i,
    input logic              rx_valid_o,
    input logic              tx_taken_o,
    input logic              op_done_o,
    input logic              tip_o
);
    int   low_cnt;
    logic last_rd_rx, last_wr_tx;

    // Purpose: count idle bus cycles and remember the last finished access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt    <= 0;
            last_rd_rx <= 1'b0;
            last_wr_tx <= 1'b0;
        end else begin
            if (wb_cyc_o) low_cnt <= 0;
            else if (low_cnt < GAP_CYCLES + 1) low_cnt <= low_cnt + 1;
            if (wb_cyc_o && wb_ack_i) begin
                last_rd_rx <= !wb_we_o && (wb_adr_o == RXD_ADDR);
                last_wr_tx <= wb_we_o && (wb_adr_o == TXD_ADDR);
            end
        end
    end

    p_stb_tracks_cyc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o == wb_cyc_o);
    p_gap_before_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_cyc_o) |-> low_cnt >= GAP_CYCLES);
    p_release_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o && wb_ack_i |=> !wb_cyc_o);
    p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o && !wb_ack_i |=> wb_cyc_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o));
    p_write_targets_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o && wb_we_o |-> wb_adr_o == TXD_ADDR);
    p_taken_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_taken_o |-> last_wr_tx);
    p_rx_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> last_rd_rx);
    p_single_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid_o, tx_taken_o, op_done_o}));
    p_done_drops_tip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_o |-> !tip_o);
endmodule

bind spi_poll_svc spi_poll_svc_chk #(
    .ADDR_W(ADDR_W), .GAP_CYCLES(GAP_CYCLES),
    .TXD_ADDR(TXD_ADDR), .RXD_ADDR(RXD_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
    .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_ack_i(wb_ack_i),
    .rx_valid_o(rx_valid_o), .tx_taken_o(tx_taken_o),
    .op_done_o(op_done_o), .tip_o(tip_o)
);

// File: tb/spi_poll_svc_tb.sv
// Bench: behavioural register-mapped SPI slave with serial timing counted in
// bus cycles. It sweeps ack latency, lead time, byte count, byte period and tail.
module spi_poll_svc_tb;
    localparam logic [7:0] A_STAT = 8'h06, A_TX = 8'h0D, A_RX = 8'h0E;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       wb_cyc, wb_stb, wb_we, tx_taken, rx_valid, op_done, tip;
    logic [7:0] wb_adr, wb_dout, rx_byte, tx_byte;
    logic [7:0] wb_din = 8'h00;
    logic       ack = 1'b0;

    spi_poll_svc u_dut (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_o(wb_cyc), .wb_stb_o(wb_stb), .wb_we_o(wb_we),
        .wb_adr_o(wb_adr), .wb_dat_o(wb_dout), .wb_dat_i(wb_din), .wb_ack_i(ack),
        .tx_byte_i(tx_byte), .tx_taken_o(tx_taken),
        .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
        .op_done_o(op_done), .tip_o(tip)
    );

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_tx(input int k);
        return 8'(k * 29 + 3);
    endfunction
    function automatic logic [7:0] mosi_b(input int op, input int k);
        return 8'(op * 37 + k * 11 + 5);
    endfunction

    // configuration written by the stimulus
    int cfg_w = 1, cfg_lt = 2, cfg_ls = 32, cfg_n = 1, cfg_bp = 40, cfg_tail = 0;
    int op_idx = 0, req_cnt = 0;
    // state written only by the model block
    int taken_cnt = 0, done_cnt = 0, rx_idx = 0, fin_cnt = 0, start_cnt = 0;
    int t, bt, bidx, tcnt, base, wcnt, lowcnt;
    bit active, armed, inbyte, ending, do_start, in_acc;
    bit m_tip, rrdy, txfull, stat_seen, s_tip, s_trdy, s_rrdy;
    logic [7:0] txreg, rxreg;

    assign tx_byte = exp_tx(taken_cnt);

    // peripheral model and bus slave, evaluated on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            active = 0; armed = 0; inbyte = 0; ending = 0; m_tip = 0; rrdy = 0;
            txfull = 0; stat_seen = 0; in_acc = 0; ack = 0; wcnt = 0; lowcnt = 100;
        end else begin
            if (rx_valid) begin
                chk(rx_byte == mosi_b(op_idx, rx_idx), "R6", rx_byte, mosi_b(op_idx, rx_idx));
                rx_idx++;
            end
            if (tx_taken) taken_cnt++;
            if (op_done) done_cnt++;

            do_start = 0;
            if (!active && req_cnt != start_cnt) begin
                start_cnt++; active = 1; m_tip = 1; armed = 0; t = 0; bidx = 0;
                inbyte = 0; ending = 0; base = taken_cnt; rx_idx = 0;
            end else if (active) begin
                t++;
                if (t == cfg_lt) armed = 1;
                if (t == cfg_ls) do_start = 1;
                if (inbyte) begin
                    bt++;
                    if (bt == cfg_bp) begin
                        chk(!rrdy, "R6", rrdy, 0); // receive overrun
                        rxreg = mosi_b(op_idx, bidx); rrdy = 1; bidx++; inbyte = 0;
                        if (bidx < cfg_n) do_start = 1;
                        else begin ending = 1; tcnt = 0; end
                    end
                end
                if (do_start) begin
                    chk(txfull, "R7", txfull, 1); // transmit underrun
                    if (txfull) chk(txreg == exp_tx(base + bidx), "R7", txreg, exp_tx(base + bidx));
                    txfull = 0; inbyte = 1; bt = 0;
                end
                if (ending) begin
                    if (tcnt >= cfg_tail) begin
                        m_tip = 0; armed = 0; txfull = 0; active = 0; ending = 0; fin_cnt++;
                    end else tcnt++;
                end
            end

            if (ack) begin
                chk(!wb_cyc, "R3", wb_cyc, 0);
                ack = 0; wcnt = 0;
            end else if (wb_cyc) begin
                if (!in_acc) begin
                    in_acc = 1;
                    chk(lowcnt >= 1 && wb_stb, "R2", lowcnt, 1);
                    if (stat_seen) begin
                        stat_seen = 0;
                        chk(tip == s_tip, "R9", tip, s_tip);
                        if (s_rrdy)
                            chk(wb_adr == A_RX && !wb_we, s_trdy ? "R10" : "R6", wb_adr, A_RX);
                        else if (s_tip && s_trdy)
                            chk(wb_adr == A_TX && wb_we, "R7", wb_adr, A_TX);
                        else
                            chk(wb_adr == A_STAT && !wb_we, "R4", wb_adr, A_STAT);
                    end
                end
                if (wcnt >= cfg_w) begin
                    ack = 1; in_acc = 0;
                    if (wb_we) begin
                        chk(wb_adr == A_TX, "R7", wb_adr, A_TX);
                        chk(m_tip && armed && !txfull, "R5", {m_tip, armed, txfull}, 3'b110);
                        txreg = wb_dout; txfull = 1;
                    end else if (wb_adr == A_RX) begin
                        wb_din = rxreg; rrdy = 0;
                    end else begin
                        s_tip = m_tip; s_trdy = armed && !txfull && m_tip; s_rrdy = rrdy;
                        wb_din = {s_tip, 2'b00, s_trdy, s_rrdy, 3'b000};
                        stat_seen = 1;
                    end
                end else wcnt++;
            end
            lowcnt = wb_cyc ? 0 : lowcnt + 1;
        end
    end

    // stimulus: reset check, then the configuration sweep
    initial begin
        int d0, t0;
        repeat (4) @(negedge clk);
        chk({wb_cyc, wb_stb, rx_valid, tx_taken, op_done, tip} == 6'b0, "R1",
            {wb_cyc, wb_stb, rx_valid, tx_taken, op_done, tip}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        for (int w = 1; w <= 3; w++)
            for (int li = 0; li < 2; li++)
                for (int ni = 0; ni < 3; ni++)
                    for (int bi = 0; bi < 2; bi++) begin
                        cfg_w = w; cfg_lt = (li != 0) ? 40 : 2; cfg_ls = cfg_lt + 30;
                        cfg_n = (ni == 0) ? 1 : ((ni == 1) ? 2 : 5);
                        cfg_bp = (bi != 0) ? 64 : 40;
                        cfg_tail = ((w + ni + bi) % 2 != 0) ? 9 : 0;
                        op_idx++;
                        d0 = done_cnt; t0 = taken_cnt;
                        req_cnt++;
                        while (fin_cnt != req_cnt) @(negedge clk);
                        repeat (40) @(negedge clk);
                        chk(rx_idx == cfg_n, "R6", rx_idx, cfg_n);
                        chk(done_cnt == d0 + 1, "R8", done_cnt - d0, 1);
                        chk(taken_cnt - t0 == cfg_n + 1, "R7", taken_cnt - t0, cfg_n + 1);
                        chk(tip == 1'b0, "R9", tip, 0);
                    end
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk({wb_cyc, tip} == 2'b0, "R1", {wb_cyc, tip}, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule